// File: doc/BRIEF.md
# Bulk IN Transfer Sequencer

This block controls one transmit channel of a USB function's bulk IN endpoint. A local host sets a transfer through a 16-bit control word on a small register bus. The word gives a size and says whether that size counts bytes or whole endpoint buffers. Setting the start bit arms the transfer. After that, the USB core raises `in_req` once for each IN transaction. The block offers the length of the next packet on `pkt_len`, counts the remaining size down, and sets a sticky done interrupt when the transfer is complete.

In byte mode the final packet is the first one shorter than a buffer. When the byte count is an exact multiple of the buffer size, one extra zero-length packet ends the transfer. In buffer mode every packet is one full buffer, which allows transfers longer than the 10-bit byte count can express. Register writes cannot stop a transfer once it runs. Only the endpoint-clear input aborts it. A USB bus reset returns the channel to its reset state, just as the local reset does.

Top module: `usb_in_dma_seq`

## Requirements
- R1: Address 0 is the control word. A read returns bit 15 = size mode (1 = bytes, 0 = buffers), bit 14 = 0, bits 13..10 = 0, and bits 9..0 = the remaining size count. Address 1 is the status word. A read returns bit 0 = done and bit 1 = busy, with every other bit 0.
- R2: A write to address 0 while idle stores bit 15 as the mode and bits 9..0 as the size. If bit 14 is 1, the write also starts a transfer. If bit 14 is 0, no transfer starts.
- R3: In byte mode, while busy, `pkt_len` equals the smaller of BUF_BYTES and the remaining count. Each accepted `in_req` lowers the count by that length.
- R4: In byte mode the transfer ends, and done is set, on the `in_req` whose packet is shorter than BUF_BYTES. If the size is an exact nonzero multiple of BUF_BYTES, this means a trailing zero-length packet.
- R5: A byte-mode start with size 0 offers a single zero-length packet and then sets done.
- R6: In buffer mode, every packet is BUF_BYTES long and each `in_req` lowers the count by 1. Done is set on the `in_req` taken with count 1. A buffer-mode start with size 0 sets done at once and sends no packet.
- R7: While busy, writes to address 0 are ignored, including a new start.
- R8: `ep_clr` aborts the transfer: the channel is idle from the next cycle and done is not set. A start in the same cycle as `ep_clr` is dropped.
- R9: Done stays set until a write to address 1 with bit 0 = 1. If a completion falls in the same cycle as that write, done stays set.
- R10: `bus_rst`, like `rst_n`, clears the mode, busy, done and the count.
- R11: An `in_req` while idle has no effect, and `pkt_len` reads 0 while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Local asynchronous reset, active low |
| bus_rst | input | 1 | USB bus reset, synchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| in_req | input | 1 | IN transaction taken by the USB core |
| ep_clr | input | 1 | Endpoint clear, aborts the transfer |
| pkt_len | output | 7 | Length of the next packet, 0 when idle |
| xfer_busy | output | 1 | Transfer in progress |
| done_irq | output | 1 | Sticky transfer-done interrupt |

## Verification
Directed cases cover byte sizes below one buffer, exact multiples of the buffer, and non-multiples above one buffer. These separate the short-final-packet rule from the trailing zero-length packet. Zero sizes in both modes separate the single empty packet from the immediate completion. Buffer-mode runs show that the count drops by one per packet rather than by the byte length. Random operation sequences then interleave starts, writes while busy, done clears, aborts and bus resets. These expose priority mistakes between abort, completion and register writes.

// File: rtl/usb_in_dma_pkg.sv
package usb_in_dma_pkg;

  // Length of the next packet for the given mode and remaining count.
  function automatic int next_len(bit byte_mode, int remain, int buf_sz);
    if (!byte_mode) return buf_sz;
    return (remain < buf_sz) ? remain : buf_sz;
  endfunction

  // True when the packet taken now finishes the transfer.
  function automatic bit is_final(bit byte_mode, int remain, int buf_sz);
    if (byte_mode) return remain < buf_sz;
    return remain == 1;
  endfunction

  // Count left after one packet has been taken.
  function automatic int after_take(bit byte_mode, int remain, int buf_sz);
    return byte_mode ? remain - next_len(1'b1, remain, buf_sz) : remain - 1;
  endfunction

endpackage

// File: rtl/usb_in_len_eng.sv
module usb_in_len_eng
  import usb_in_dma_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int BUF_BYTES = 64,
  parameter int LEN_W     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_rst,
  input  logic             ctl_wr,
  input  logic             wr_mode,
  input  logic             wr_start,
  input  logic [CNT_W-1:0] wr_size,
  input  logic             in_req,
  input  logic             ep_clr,
  output logic             busy,
  output logic             byte_mode,
  output logic [CNT_W-1:0] remain,
  output logic [LEN_W-1:0] pkt_len,
  output logic             fin_evt
);

  logic take_evt;   // accepted IN transaction
  logic load_evt;   // control write that is accepted
  logic start_evt;  // load that asks for a start
  logic empty_buf;  // buffer-mode start with size 0
  logic last_pkt;

  always_comb begin
    pkt_len   = busy ? LEN_W'(next_len(byte_mode, int'(remain), BUF_BYTES)) : '0;
    last_pkt  = is_final(byte_mode, int'(remain), BUF_BYTES);
    take_evt  = busy && in_req && !ep_clr && !bus_rst;
    load_evt  = ctl_wr && !busy && !ep_clr && !bus_rst;
    start_evt = load_evt && wr_start;
    empty_buf = !wr_mode && (wr_size == '0);
    fin_evt   = (take_evt && last_pkt) || (start_evt && empty_buf);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      byte_mode <= 1'b0;
      remain    <= '0;
    end else if (bus_rst) begin
      busy      <= 1'b0;
      byte_mode <= 1'b0;
      remain    <= '0;
    end else if (ep_clr) begin
      busy <= 1'b0;
    end else if (take_evt) begin
      remain <= CNT_W'(after_take(byte_mode, int'(remain), BUF_BYTES));
      if (last_pkt) busy <= 1'b0;
    end else if (load_evt) begin
      byte_mode <= wr_mode;
      remain    <= wr_size;
      busy      <= wr_start && !empty_buf;
    end
  end

  AST_BUF_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !byte_mode |-> pkt_len == LEN_W'(BUF_BYTES)); // R6
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy && byte_mode |-> (int'(pkt_len) <= int'(remain)) && (int'(pkt_len) <= BUF_BYTES)); // R3
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ep_clr |=> !busy); // R8
  AST_BUSY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ctl_wr && !in_req && !ep_clr && !bus_rst |=> busy && $stable(remain) && $stable(byte_mode)); // R7
  AST_BUSRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> !byte_mode && !busy && remain == '0); // R10
  AST_IDLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && in_req && !ctl_wr && !bus_rst |=> !busy && $stable(remain)); // R11

endmodule

// File: rtl/usb_in_done_flag.sv
module usb_in_done_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_rst,
  input  logic set_evt,
  input  logic clr_evt,
  output logic done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done <= 1'b0;
    else if (bus_rst)  done <= 1'b0;
    else if (set_evt)  done <= 1'b1;
    else if (clr_evt)  done <= 1'b0;
  end

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done && !clr_evt && !bus_rst |=> done); // R9
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt && !bus_rst |=> done); // R9

endmodule

// File: rtl/usb_in_dma_seq.sv
module usb_in_dma_seq #(
  parameter int CNT_W     = 10,
  parameter int BUF_BYTES = 64,
  parameter int LEN_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_rst,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata,
  input  logic             in_req,
  input  logic             ep_clr,
  output logic [LEN_W-1:0] pkt_len,
  output logic             xfer_busy,
  output logic             done_irq
);

  localparam int RSV_W = 15 - CNT_W;

  logic             ctl_wr;
  logic             sts_clr;
  logic             byte_mode;
  logic             fin_evt;
  logic [CNT_W-1:0] remain;
  logic             unused_rsvd;

  assign ctl_wr      = reg_we && !reg_addr;
  assign sts_clr     = reg_we && reg_addr && reg_wdata[0];
  assign unused_rsvd = ^reg_wdata[13:CNT_W];

  usb_in_len_eng #(.CNT_W(CNT_W), .BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rst   (bus_rst),
    .ctl_wr    (ctl_wr),
    .wr_mode   (reg_wdata[15]),
    .wr_start  (reg_wdata[14]),
    .wr_size   (reg_wdata[CNT_W-1:0]),
    .in_req    (in_req),
    .ep_clr    (ep_clr),
    .busy      (xfer_busy),
    .byte_mode (byte_mode),
    .remain    (remain),
    .pkt_len   (pkt_len),
    .fin_evt   (fin_evt)
  );

  usb_in_done_flag u_done (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_rst (bus_rst),
    .set_evt (fin_evt),
    .clr_evt (sts_clr),
    .done    (done_irq)
  );

  always_comb begin
    if (!reg_addr) reg_rdata = {byte_mode, {RSV_W{1'b0}}, remain};
    else           reg_rdata = {14'b0, xfer_busy, done_irq};
  end

  AST_ABORT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ep_clr && !done_irq |=> !done_irq); // R8
  AST_IDLE_LEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_busy |-> pkt_len == '0); // R11

endmodule

// File: tb/usb_in_dma_seq_tb.sv
module usb_in_dma_seq_tb;

  localparam int BUF = 64;
  localparam int LW  = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rst = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        in_req = 1'b0;
  logic        ep_clr = 1'b0;
  logic [LW-1:0] pkt_len;
  logic        xfer_busy;
  logic        done_irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  // reference state
  bit       m_busy, m_mode, m_done;
  int       m_rem;

  always #10ns clk = ~clk;

  usb_in_dma_seq u_dut (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .in_req(in_req), .ep_clr(ep_clr), .pkt_len(pkt_len),
    .xfer_busy(xfer_busy), .done_irq(done_irq)
  );

  function automatic int exp_len();
    if (!m_busy) return 0;
    if (m_mode && m_rem <= BUF) return m_rem;
    return BUF;
  endfunction

  function automatic logic [15:0] exp_rd(logic a);
    if (a) return {14'b0, m_busy, m_done};
    return {m_mode, 5'b0, 10'(m_rem)};
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  // Applies one cycle of inputs, checks the outputs seen before the edge,
  // then advances the reference.
  task automatic cyc(string tag, logic we, logic a, logic [15:0] wd,
                     logic req, logic clr, logic brst);
    int len;
    reg_we = we; reg_addr = a; reg_wdata = wd;
    in_req = req; ep_clr = clr; bus_rst = brst;
    #1;
    chk({tag, " pkt_len"}, int'(pkt_len), exp_len());
    chk({tag, " busy"}, int'(xfer_busy), int'(m_busy));
    chk({tag, " done"}, int'(done_irq), int'(m_done));
    chk({tag, " rdata"}, int'(reg_rdata), int'(exp_rd(a)));
    len = exp_len();
    if (brst) begin
      m_busy = 0; m_mode = 0; m_rem = 0; m_done = 0;
    end else begin
      if (we && a && wd[0]) m_done = 0;
      if (clr) m_busy = 0;
      else if (m_busy && req) begin
        if (m_mode) begin
          m_rem = m_rem - len;
          if (len < BUF) begin m_busy = 0; m_done = 1; end
        end else begin
          if (m_rem == 1) begin m_busy = 0; m_done = 1; end
          m_rem = m_rem - 1;
        end
      end else if (!m_busy && we && !a) begin
        m_mode = wd[15];
        m_rem  = int'(wd[9:0]);
        if (wd[14]) begin
          if (!wd[15] && wd[9:0] == 0) m_done = 1;
          else m_busy = 1;
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(string tag);
    cyc(tag, 0, 0, 16'h0, 0, 0, 0);
  endtask

  task automatic ctl(string tag, bit mode, bit start, int size);
    cyc(tag, 1, 0, {mode, start, 4'b0, 10'(size)}, 0, 0, 0);
  endtask

  task automatic req(string tag);
    cyc(tag, 0, 1, 16'h0, 1, 0, 0);
  endtask

  task automatic clr_done(string tag);
    cyc(tag, 1, 1, 16'h0001, 0, 0, 0);
  endtask

  // Runs a whole transfer and checks the packet count it took.
  task automatic run_xfer(string tag, bit mode, int size, int exp_pkts);
    int pk = 0;
    ctl(tag, mode, 1, size);
    while (m_busy && pk < 40) begin req(tag); pk++; end
    idle(tag);
    chk({tag, " packets"}, pk, exp_pkts);
    chk({tag, " done set"}, int'(done_irq), 1);
    clr_done("R9");
  endtask

  initial begin
    #(20ns * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    m_busy = 0; m_mode = 0; m_rem = 0; m_done = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R10 reset busy", int'(xfer_busy), 0);
    chk("R10 reset done", int'(done_irq), 0);
    chk("R1 reset rdata", int'(reg_rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: start and reserved bits read 0, size and mode are stored
    ctl("R2", 1, 0, 300);
    cyc("R1", 1, 0, 16'h3C00 | 16'h8000 | 16'd5, 0, 0, 0);
    idle("R1");
    chk("R1 ctl read", int'(reg_rdata), 32'h8005);
    chk("R2 no start", int'(xfer_busy), 0);

    // R11: in_req while idle
    req("R11"); idle("R11");
    chk("R11 rem kept", int'(reg_rdata[9:0]), 5);

    // R3/R4 byte mode
    run_xfer("R4 short", 1, 40, 1);
    run_xfer("R3 non-multiple", 1, 100, 2);
    run_xfer("R4 exact multiple", 1, 128, 3);
    run_xfer("R4 one buffer", 1, 64, 2);
    run_xfer("R3 max bytes", 1, 1023, 16);
    // R5 zero byte transfer
    run_xfer("R5 zero bytes", 1, 0, 1);
    // R6 buffer mode
    run_xfer("R6 buffers", 0, 3, 3);
    run_xfer("R6 zero buffers", 0, 0, 0);

    // R7: writes while busy are ignored
    ctl("R7", 1, 1, 200);
    req("R7");
    ctl("R7", 0, 1, 7);
    cyc("R7", 1, 0, 16'h0000, 0, 0, 0);
    idle("R7");
    chk("R7 rem", int'(reg_rdata[9:0]), 136);
    chk("R7 mode", int'(reg_rdata[15]), 1);

    // R8: abort does not set done
    cyc("R8", 0, 0, 16'h0, 0, 1, 0);
    idle("R8");
    chk("R8 idle", int'(xfer_busy), 0);
    chk("R8 no done", int'(done_irq), 0);
    cyc("R8", 1, 0, 16'hC010, 0, 1, 0);
    idle("R8");
    chk("R8 start dropped", int'(xfer_busy), 0);

    // R9: completion beats a same-cycle clear
    ctl("R9", 1, 1, 10);
    cyc("R9", 1, 1, 16'h0001, 1, 0, 0);
    idle("R9");
    chk("R9 set wins", int'(done_irq), 1);
    clr_done("R9");
    chk("R9 cleared", int'(done_irq), 0);

    // R10: bus reset clears mode and stops a transfer
    ctl("R10", 1, 1, 500);
    cyc("R10", 0, 0, 16'h0, 0, 0, 1);
    idle("R10");
    chk("R10 mode", int'(reg_rdata[15]), 0);
    chk("R10 busy", int'(xfer_busy), 0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom % 100);
      bit md = $urandom % 2;
      int sz = md ? ((($urandom % 3) == 0) ? BUF * int'($urandom % 5) : int'($urandom % 1024))
                  : int'($urandom % 10);
      logic [15:0] wd = {md, 1'b0, 4'($urandom), 10'(sz)};
      if (r < 45)      cyc("R3", 0, $urandom % 2, 16'h0, 1, 0, 0);
      else if (r < 57) begin wd[14] = 1; cyc("R2", 1, 0, wd, 0, 0, 0); end
      else if (r < 63) cyc("R7", 1, 0, wd, $urandom % 2, 0, 0);
      else if (r < 71) cyc("R9", 1, 1, 16'($urandom), $urandom % 2, 0, 0);
      else if (r < 74) cyc("R8", $urandom % 2, 0, wd | 16'h4000, 0, 1, 0);
      else if (r < 76) cyc("R10", 0, 0, 16'h0, 0, 0, 1);
      else             cyc("R6", 0, $urandom % 2, 16'h0, 0, 0, 0);
    end
    idle("R1");
    summary();
  end

endmodule